// File: doc/BRIEF.md
# USB full-speed IN transaction engine

This block is the device-side engine for USB full-speed IN transfers on a small set of endpoints. It watches the decoded strobes of the packet receiver for tokens aimed at this device and picks the addressed endpoint. It then answers with a data packet, a STALL or a NAK. While sending data, it streams the payload out of an external buffer through a byte-address and byte-get handshake. After a data packet it waits for the host's handshake, bounded by a timeout counted in bit times.

Each endpoint keeps its own data toggle. An accepted ACK flips the toggle, and a SETUP token or a link reset clears it. Isochronous endpoints never wait for a handshake. The engine reports a delivered packet by pulsing the endpoint's bit on a per-endpoint sent vector. Bit coding, CRC and the buffer memory itself belong to neighbouring blocks.

Top module: `usb_in_engine`

States: Idle, RcvdIn, SendData, WaitTxEnd, WaitAckStart, WaitAck.

Transitions:
- Idle→RcvdIn: an IN token arrives for an active endpoint.
- RcvdIn→SendData: the endpoint is isochronous, or it has data pending.
- RcvdIn→WaitTxEnd: the engine answers with STALL or NAK.
- SendData→WaitTxEnd: the payload ends on an isochronous endpoint.
- SendData→WaitAckStart: the payload ends on any other endpoint.
- WaitTxEnd→Idle: transmit end.
- WaitAckStart→WaitAck: a receive packet starts.
- WaitAckStart→Idle: the timeout expires.
- WaitAck→Idle: an ACK arrives, or any other packet ends.
- WaitAck→RcvdIn: a new IN token arrives (retry).
- Any state→Idle: link reset, link inactive, or an illegal encoding.

## Requirements
- R1: An IN token (PID 4'b1001) is accepted only in a cycle with rx_pkt_end_i and rx_pkt_valid_i high, PID bits [1:0] equal to 2'b01 and rx_addr_i equal to dev_addr_i. Any other such packet raises no tx_pkt_start_o.
- R2: An endpoint is active only when its number is below NUM_EP and its bit in ep_enabled_i is set. A token that names an inactive endpoint is ignored.
- R3: tx_pkt_start_o is high for exactly the one cycle after the token's end cycle. tx_pid_o takes its value in the following cycle and holds it until the next start. Priority for tx_pid_o:
  - an isochronous endpoint sends data;
  - otherwise a stalled endpoint gets STALL (4'b1110);
  - otherwise an endpoint with data pending (has-data set, done clear) gets data;
  - otherwise the endpoint gets NAK (4'b1010).
- R4: A data packet carries DATA0 (4'b0011) when the endpoint's toggle is 0 and DATA1 (4'b1011) when it is 1. All toggles are 0 after reset.
- R5: buf_addr_o is 0 when a data phase begins and rises by one on every tx_data_get_i taken during it. tx_data_avail_o is high while data is sending and the endpoint still has data pending.
- R6: The data phase ends when pending data clears, or when a byte is taken at buf_addr_o all ones.
- R7: After a non-isochronous data packet and its transmit end, an ACK (PID 4'b0010, valid, at packet end) returns the engine to idle. In that same cycle the ACK pulses the endpoint's in_sent_o bit and flips its toggle.
- R8: Transmit end loads TIMEOUT_BITS, and each bit_strobe_i counts it down by one. At zero with no receive start, the engine goes idle and the toggle is unchanged. A receive start in the cycle the count reaches zero still opens the handshake wait.
- R9: An accepted IN token while waiting for the handshake restarts the response with the same data PID and byte address 0.
- R10: Any other packet end while waiting for the handshake returns to idle with no in_sent_o pulse and no toggle change.
- R11: An isochronous data packet skips the handshake. Its in_sent_o bit pulses with tx_pkt_end_i and its toggle is not changed.
- R12: A SETUP token (PID 4'b1101) to an active endpoint clears that endpoint's toggle.
- R13: link_reset_i forces the engine idle from the next cycle and clears every toggle. link_active_i low also forces idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_reset_i | input | 1 | Bus reset seen on the link |
| link_active_i | input | 1 | Link is active |
| bit_strobe_i | input | 1 | One pulse per bit time |
| dev_addr_i | input | 7 | Programmed device address |
| rx_pkt_start_i | input | 1 | Receive packet start strobe |
| rx_pkt_end_i | input | 1 | Receive packet end strobe |
| rx_pkt_valid_i | input | 1 | Received packet was valid |
| rx_pid_i | input | 4 | Received PID |
| rx_addr_i | input | 7 | Received token address |
| rx_endp_i | input | 4 | Received token endpoint |
| ep_enabled_i | input | NUM_EP | Per-endpoint enable |
| ep_iso_i | input | NUM_EP | Per-endpoint isochronous mode |
| ep_stall_i | input | NUM_EP | Per-endpoint stall |
| ep_has_data_i | input | NUM_EP | Per-endpoint data ready |
| ep_data_done_i | input | NUM_EP | Per-endpoint payload finished |
| tx_pkt_start_o | output | 1 | Start a transmit packet |
| tx_pid_o | output | 4 | PID to transmit |
| tx_pkt_end_i | input | 1 | Transmit packet end strobe |
| tx_data_avail_o | output | 1 | Payload byte available |
| tx_data_get_i | input | 1 | Transmitter takes a byte |
| buf_addr_o | output | BUF_AW | Payload byte address |
| in_sent_o | output | NUM_EP | Per-endpoint packet delivered pulse |

## Verification
The handshake timeout and the start of the host's reply can land in the same cycle. The bench provokes this by issuing exactly TIMEOUT_BITS bit strobes after transmit end and then raising rx_pkt_start_i while the count sits at zero. It judges the outcome by sending an ACK next. The ACK must still pulse in_sent_o for that endpoint. The next IN on that endpoint must carry the flipped data PID, which would not happen if the engine had dropped to idle on the expiry.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;

    typedef enum logic [2:0] {
        S_IDLE           = 3'd0,
        S_RCVD_IN        = 3'd1,
        S_SEND_DATA      = 3'd2,
        S_WAIT_TX_END    = 3'd3,
        S_WAIT_ACK_START = 3'd4,
        S_WAIT_ACK       = 3'd5
    } in_state_e;

    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_ACK   = 4'b0010;
    localparam logic [3:0] PID_NAK   = 4'b1010;
    localparam logic [3:0] PID_STALL = 4'b1110;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

    localparam logic [1:0] PID_KIND_TOKEN = 2'b01;

endpackage

// File: rtl/usb_in_rx_decode.sv
module usb_in_rx_decode
    import usb_in_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic           rx_pkt_end_i,
    input  logic           rx_pkt_valid_i,
    input  logic [3:0]     rx_pid_i,
    input  logic [6:0]     rx_addr_i,
    input  logic [3:0]     rx_endp_i,
    input  logic [6:0]     dev_addr_i,
    output logic           in_tok_o,
    output logic           setup_tok_o,
    output logic           ack_o,
    output logic           ep_hw_o,
    output logic [EPW-1:0] ep_idx_o
);

    logic pkt_ok;
    logic token_ok;

    assign pkt_ok      = rx_pkt_end_i && rx_pkt_valid_i;
    assign token_ok    = pkt_ok && (rx_pid_i[1:0] == PID_KIND_TOKEN) && (rx_addr_i == dev_addr_i);
    assign in_tok_o    = token_ok && (rx_pid_i == PID_IN);
    assign setup_tok_o = token_ok && (rx_pid_i == PID_SETUP);
    assign ack_o       = pkt_ok && (rx_pid_i == PID_ACK);
    assign ep_hw_o     = ({28'd0, rx_endp_i} < 32'(NUM_EP));
    assign ep_idx_o    = ep_hw_o ? rx_endp_i[EPW-1:0] : '0;

endmodule

// File: rtl/usb_in_toggle.sv
module usb_in_toggle #(
    parameter int NUM_EP = 4,
    parameter int EPW    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_all_i,
    input  logic              clr_en_i,
    input  logic [EPW-1:0]    clr_idx_i,
    input  logic              flip_en_i,
    input  logic [EPW-1:0]    flip_idx_i,
    output logic [NUM_EP-1:0] tog_o
);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_tog
        logic bit_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                bit_q <= 1'b0;
            end else if (clr_all_i) begin
                bit_q <= 1'b0;
            end else if (clr_en_i && (clr_idx_i == EPW'(g))) begin
                bit_q <= 1'b0;
            end else if (flip_en_i && (flip_idx_i == EPW'(g))) begin
                bit_q <= ~bit_q;
            end
        end
        assign tog_o[g] = bit_q;
    end

endmodule

// File: rtl/usb_in_timeout.sv
module usb_in_timeout #(
    parameter int TIMEOUT_BITS = 18
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic load_i,
    input  logic tick_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (clear_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= CNT_W'(TIMEOUT_BITS);
            armed_q <= 1'b1;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign expired_o = armed_q && (cnt_q == '0);

endmodule

// File: rtl/usb_in_engine.sv
module usb_in_engine
    import usb_in_pkg::*;
#(
    parameter int NUM_EP       = 4,
    parameter int BUF_AW       = 5,
    parameter int TIMEOUT_BITS = 18
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              link_reset_i,
    input  logic              link_active_i,
    input  logic              bit_strobe_i,
    input  logic [6:0]        dev_addr_i,
    input  logic              rx_pkt_start_i,
    input  logic              rx_pkt_end_i,
    input  logic              rx_pkt_valid_i,
    input  logic [3:0]        rx_pid_i,
    input  logic [6:0]        rx_addr_i,
    input  logic [3:0]        rx_endp_i,
    input  logic [NUM_EP-1:0] ep_enabled_i,
    input  logic [NUM_EP-1:0] ep_iso_i,
    input  logic [NUM_EP-1:0] ep_stall_i,
    input  logic [NUM_EP-1:0] ep_has_data_i,
    input  logic [NUM_EP-1:0] ep_data_done_i,
    output logic              tx_pkt_start_o,
    output logic [3:0]        tx_pid_o,
    input  logic              tx_pkt_end_i,
    output logic              tx_data_avail_o,
    input  logic              tx_data_get_i,
    output logic [BUF_AW-1:0] buf_addr_o,
    output logic [NUM_EP-1:0] in_sent_o
);

    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;

    in_state_e          state_q, state_d;
    logic [EPW-1:0]     cur_ep_q;
    logic [3:0]         pid_q;
    logic [BUF_AW-1:0]  addr_q;

    logic               in_tok, setup_tok, ack_seen, ep_hw;
    logic [EPW-1:0]     ep_idx_d;
    logic               ep_active_d, in_go;
    logic               force_idle;
    logic               cur_iso, cur_stall, pending, last_byte;
    logic               expired;
    logic [NUM_EP-1:0]  tog;
    logic               flip_en, iso_done;

    usb_in_rx_decode #(.NUM_EP(NUM_EP), .EPW(EPW)) u_dec (
        .rx_pkt_end_i  (rx_pkt_end_i),
        .rx_pkt_valid_i(rx_pkt_valid_i),
        .rx_pid_i      (rx_pid_i),
        .rx_addr_i     (rx_addr_i),
        .rx_endp_i     (rx_endp_i),
        .dev_addr_i    (dev_addr_i),
        .in_tok_o      (in_tok),
        .setup_tok_o   (setup_tok),
        .ack_o         (ack_seen),
        .ep_hw_o       (ep_hw),
        .ep_idx_o      (ep_idx_d)
    );

    assign ep_active_d = ep_hw && ep_enabled_i[ep_idx_d];
    assign in_go       = in_tok && ep_active_d;
    assign force_idle  = link_reset_i || !link_active_i;

    assign cur_iso   = ep_iso_i[cur_ep_q];
    assign cur_stall = ep_stall_i[cur_ep_q];
    assign pending   = ep_has_data_i[cur_ep_q] && !ep_data_done_i[cur_ep_q];
    assign last_byte = (&addr_q) && tx_data_get_i;

    usb_in_timeout #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_tmo (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  ((state_q == S_IDLE) || (state_q == S_RCVD_IN)),
        .load_i   (tx_pkt_end_i),
        .tick_i   (bit_strobe_i && (state_q == S_WAIT_ACK_START)),
        .expired_o(expired)
    );

    usb_in_toggle #(.NUM_EP(NUM_EP), .EPW(EPW)) u_tog (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_all_i (link_reset_i),
        .clr_en_i  (setup_tok && ep_active_d),
        .clr_idx_i (ep_idx_d),
        .flip_en_i (flip_en),
        .flip_idx_i(cur_ep_q),
        .tog_o     (tog)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (force_idle) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (in_go) state_d = S_RCVD_IN;
                end
                S_RCVD_IN: begin
                    if (cur_iso)        state_d = S_SEND_DATA;
                    else if (cur_stall) state_d = S_WAIT_TX_END;
                    else if (pending)   state_d = S_SEND_DATA;
                    else                state_d = S_WAIT_TX_END;
                end
                S_SEND_DATA: begin
                    if (!pending || last_byte)
                        state_d = cur_iso ? S_WAIT_TX_END : S_WAIT_ACK_START;
                end
                S_WAIT_TX_END: begin
                    if (tx_pkt_end_i) state_d = S_IDLE;
                end
                S_WAIT_ACK_START: begin
                    if (rx_pkt_start_i) state_d = S_WAIT_ACK;
                    else if (expired)   state_d = S_IDLE;
                end
                S_WAIT_ACK: begin
                    if (ack_seen)          state_d = S_IDLE;
                    else if (in_go)        state_d = S_RCVD_IN;
                    else if (rx_pkt_end_i) state_d = S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_ep_q <= '0;
            pid_q    <= PID_NAK;
            addr_q   <= '0;
        end else begin
            if (in_go) cur_ep_q <= ep_idx_d;
            if (state_q == S_RCVD_IN) begin
                if (cur_iso || (!cur_stall && pending)) pid_q <= tog[cur_ep_q] ? PID_DATA1 : PID_DATA0;
                else if (cur_stall)                     pid_q <= PID_STALL;
                else                                    pid_q <= PID_NAK;
            end
            if ((state_q == S_IDLE) || (state_q == S_RCVD_IN)) addr_q <= '0;
            else if ((state_q == S_SEND_DATA) && tx_data_get_i) addr_q <= addr_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        flip_en         = !force_idle && (state_q == S_WAIT_ACK) && ack_seen;
        iso_done        = !force_idle && (state_q == S_WAIT_TX_END) && tx_pkt_end_i && cur_iso;
        tx_pkt_start_o  = (state_q == S_RCVD_IN);
        tx_data_avail_o = (state_q == S_SEND_DATA) && pending;
        tx_pid_o        = pid_q;
        buf_addr_o      = addr_q;
        in_sent_o       = (flip_en || iso_done) ? (NUM_EP'(1) << cur_ep_q) : '0;
    end

endmodule

// File: rtl/usb_in_engine_chk.sv
module usb_in_engine_chk #(
    parameter int NUM_EP = 4,
    parameter int BUF_AW = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              link_reset_i,
    input logic              link_active_i,
    input logic              rx_pkt_end_i,
    input logic              rx_pkt_valid_i,
    input logic              tx_pkt_start_o,
    input logic [3:0]        tx_pid_o,
    input logic              tx_data_avail_o,
    input logic              tx_data_get_i,
    input logic [BUF_AW-1:0] buf_addr_o,
    input logic [NUM_EP-1:0] in_sent_o
);

    a_r1_start_after_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pkt_start_o |-> $past(rx_pkt_end_i && rx_pkt_valid_i));

    a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pkt_start_o |=> !tx_pkt_start_o);

    a_r3_pid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(tx_pkt_start_o) |-> $stable(tx_pid_o));

    a_r5_addr_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_pkt_start_o |=> (buf_addr_o == '0));

    a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_data_avail_o && tx_data_get_i && link_active_i && !link_reset_i)
        |=> (buf_addr_o == BUF_AW'($past(buf_addr_o) + 1'b1)));

    a_r7_sent_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(in_sent_o));

    a_r13_link_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_reset_i |=> (!tx_pkt_start_o && !tx_data_avail_o));

endmodule

bind usb_in_engine usb_in_engine_chk #(.NUM_EP(NUM_EP), .BUF_AW(BUF_AW)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .link_reset_i   (link_reset_i),
    .link_active_i  (link_active_i),
    .rx_pkt_end_i   (rx_pkt_end_i),
    .rx_pkt_valid_i (rx_pkt_valid_i),
    .tx_pkt_start_o (tx_pkt_start_o),
    .tx_pid_o       (tx_pid_o),
    .tx_data_avail_o(tx_data_avail_o),
    .tx_data_get_i  (tx_data_get_i),
    .buf_addr_o     (buf_addr_o),
    .in_sent_o      (in_sent_o)
);

// File: tb/sim_usb_in_engine.sv
module sim_usb_in_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NEP  = 4;
    localparam int BAW  = 5;
    localparam int TMO  = 18;
    localparam logic [6:0] DEV = 7'h2A;

    localparam logic [3:0] P_IN = 4'b1001, P_SETUP = 4'b1101, P_ACK = 4'b0010;
    localparam logic [3:0] P_NAK = 4'b1010, P_STALL = 4'b1110;
    localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;

    // {ep[1:0], iso, stall, has, nbytes[3:0], resp[1:0] (0 ack,1 timeout,2 other), pad, pid[3:0]}
    localparam int NVEC = 9;
    localparam logic [15:0] VEC [NVEC] = '{
        {2'd1, 1'b0, 1'b0, 1'b1, 4'd3, 2'd0, 1'b0, P_D0},
        {2'd1, 1'b0, 1'b0, 1'b1, 4'd2, 2'd0, 1'b0, P_D1},
        {2'd2, 1'b0, 1'b1, 1'b1, 4'd0, 2'd0, 1'b0, P_STALL},
        {2'd3, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b0, P_NAK},
        {2'd0, 1'b0, 1'b0, 1'b1, 4'd1, 2'd1, 1'b0, P_D0},
        {2'd0, 1'b0, 1'b0, 1'b1, 4'd4, 2'd0, 1'b0, P_D0},
        {2'd2, 1'b1, 1'b0, 1'b1, 4'd2, 2'd0, 1'b0, P_D0},
        {2'd0, 1'b0, 1'b0, 1'b1, 4'd1, 2'd2, 1'b0, P_D1},
        {2'd0, 1'b0, 1'b0, 1'b1, 4'd1, 2'd0, 1'b0, P_D1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_reset = 1'b0, link_active = 1'b1, bit_strobe = 1'b0;
    logic rx_start = 1'b0, rx_end = 1'b0, rx_valid = 1'b1;
    logic [3:0] rx_pid = 4'd0;
    logic [6:0] rx_addr = 7'd0;
    logic [3:0] rx_endp = 4'd0;
    logic [NEP-1:0] ep_en = '1, ep_iso = '0, ep_stall = '0, ep_has = '0, ep_done = '0;
    logic tx_end = 1'b0, tx_get = 1'b0;
    logic tx_start, tx_avail;
    logic [3:0] tx_pid;
    logic [BAW-1:0] buf_addr;
    logic [NEP-1:0] in_sent;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_in_engine #(.NUM_EP(NEP), .BUF_AW(BAW), .TIMEOUT_BITS(TMO)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .link_reset_i(link_reset), .link_active_i(link_active),
        .bit_strobe_i(bit_strobe), .dev_addr_i(DEV), .rx_pkt_start_i(rx_start),
        .rx_pkt_end_i(rx_end), .rx_pkt_valid_i(rx_valid), .rx_pid_i(rx_pid),
        .rx_addr_i(rx_addr), .rx_endp_i(rx_endp), .ep_enabled_i(ep_en), .ep_iso_i(ep_iso),
        .ep_stall_i(ep_stall), .ep_has_data_i(ep_has), .ep_data_done_i(ep_done),
        .tx_pkt_start_o(tx_start), .tx_pid_o(tx_pid), .tx_pkt_end_i(tx_end),
        .tx_data_avail_o(tx_avail), .tx_data_get_i(tx_get), .buf_addr_o(buf_addr),
        .in_sent_o(in_sent)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic token(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] endp);
        rx_pid = pid; rx_addr = addr; rx_endp = endp; rx_end = 1'b1;
        step();
        rx_end = 1'b0;
    endtask

    task automatic stream(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R5 addr", 32'(buf_addr), 32'(i));
            chk("R5 avail", 32'(tx_avail), 32'd1);
            tx_get = 1'b1; step(); tx_get = 1'b0;
        end
    endtask

    task automatic ack_now(input int ep, input string req);
        rx_pid = P_ACK; rx_end = 1'b1; #1;
        chk(req, 32'(in_sent), 32'(1) << ep);
        step(); rx_end = 1'b0; step();
        chk(req, 32'(buf_addr), 32'd0);
    endtask

    task automatic run_vec(input logic [15:0] v);
        int ep, n;
        logic is_data;
        ep = int'(v[15:14]); n = int'(v[10:7]);
        ep_iso = v[13] ? (NEP'(1) << ep) : '0;
        ep_stall = v[12] ? (NEP'(1) << ep) : '0;
        ep_has[ep] = v[11];
        ep_done = '0;
        is_data = (v[3:0] == P_D0) || (v[3:0] == P_D1);
        step();
        token(P_IN, DEV, 4'(ep));
        chk("R3 start", 32'(tx_start), 32'd1);
        step();
        chk("R3 R4 pid", 32'(tx_pid), 32'(v[3:0]));
        if (!is_data) begin
            chk("R3 no data", 32'(tx_avail), 32'd0);
            tx_end = 1'b1; #1;
            chk("R3 no sent", 32'(in_sent), 32'd0);
            step(); tx_end = 1'b0;
            return;
        end
        stream(n);
        ep_done[ep] = 1'b1; step();
        chk("R6 end", 32'(tx_avail), 32'd0);
        if (v[13]) begin
            tx_end = 1'b1; #1;
            chk("R11 iso sent", 32'(in_sent), 32'(1) << ep);
            step(); tx_end = 1'b0;
            return;
        end
        tx_end = 1'b1; step(); tx_end = 1'b0;
        if (v[6:5] == 2'd0) begin
            rx_start = 1'b1; step(); rx_start = 1'b0;
            ack_now(ep, "R7 ack");
        end else if (v[6:5] == 2'd1) begin
            bit_strobe = 1'b1;
            for (int i = 0; i < TMO - 1; i++) step();
            bit_strobe = 1'b0; step(); step();
            chk("R8 not early", 32'(buf_addr), 32'(n));
            bit_strobe = 1'b1; step(); bit_strobe = 1'b0; step(); step();
            chk("R8 timeout idle", 32'(buf_addr), 32'd0);
        end else begin
            rx_start = 1'b1; step(); rx_start = 1'b0;
            rx_pid = P_NAK; rx_end = 1'b1; #1;
            chk("R10 no sent", 32'(in_sent), 32'd0);
            step(); rx_end = 1'b0; step();
            chk("R10 idle", 32'(buf_addr), 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        chk("R5 reset addr", 32'(buf_addr), 32'd0);
        chk("R3 reset start", 32'(tx_start), 32'd0);
        chk("R5 reset avail", 32'(tx_avail), 32'd0);
        chk("R7 reset sent", 32'(in_sent), 32'd0);
        rst_n = 1'b1;
        step();

        // R1: wrong address, invalid packet
        ep_has = '1;
        token(P_IN, 7'h11, 4'd1);
        chk("R1 wrong addr", 32'(tx_start), 32'd0);
        rx_valid = 1'b0;
        token(P_IN, DEV, 4'd1);
        chk("R1 invalid", 32'(tx_start), 32'd0);
        rx_valid = 1'b1;
        // R2: disabled and out-of-range endpoint
        ep_en = 4'b0111;
        token(P_IN, DEV, 4'd3);
        chk("R2 disabled", 32'(tx_start), 32'd0);
        ep_en = '1;
        token(P_IN, DEV, 4'd5);
        chk("R2 out of range", 32'(tx_start), 32'd0);
        ep_has = '0;

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        // R12: setup clears toggle of endpoint 1
        run_vec({2'd1, 1'b0, 1'b0, 1'b1, 4'd1, 2'd0, 1'b0, P_D0});
        token(P_SETUP, DEV, 4'd1);
        run_vec({2'd1, 1'b0, 1'b0, 1'b1, 4'd1, 2'd0, 1'b0, P_D0});

        // R9: retry on endpoint 2
        ep_iso = '0; ep_stall = '0; ep_has[2] = 1'b1; ep_done = '0;
        step();
        token(P_IN, DEV, 4'd2);
        step();
        chk("R9 first pid", 32'(tx_pid), 32'(P_D0));
        stream(2);
        ep_done[2] = 1'b1; step();
        tx_end = 1'b1; step(); tx_end = 1'b0;
        rx_start = 1'b1; step(); rx_start = 1'b0;
        ep_done[2] = 1'b0;
        token(P_IN, DEV, 4'd2);
        chk("R9 restart", 32'(tx_start), 32'd1);
        step();
        chk("R9 same pid", 32'(tx_pid), 32'(P_D0));
        chk("R9 addr zero", 32'(buf_addr), 32'd0);
        stream(1);
        ep_done[2] = 1'b1; step();
        tx_end = 1'b1; step(); tx_end = 1'b0;
        rx_start = 1'b1; step(); rx_start = 1'b0;
        ack_now(2, "R9 ack");

        // R8: receive start in the cycle the count reaches zero
        ep_has[3] = 1'b1; ep_done = '0;
        step();
        token(P_IN, DEV, 4'd3);
        step();
        chk("R8 pid", 32'(tx_pid), 32'(P_D0));
        stream(1);
        ep_done[3] = 1'b1; step();
        tx_end = 1'b1; step(); tx_end = 1'b0;
        bit_strobe = 1'b1;
        for (int i = 0; i < TMO; i++) step();
        bit_strobe = 1'b0;
        rx_start = 1'b1; step(); rx_start = 1'b0;
        ack_now(3, "R8 race ack");
        run_vec({2'd3, 1'b0, 1'b0, 1'b1, 4'd1, 2'd0, 1'b0, P_D1});

        // R6: all-ones address ends the packet
        ep_has[0] = 1'b1; ep_done = '0;
        step();
        token(P_IN, DEV, 4'd0);
        step();
        chk("R6 pid", 32'(tx_pid), 32'(P_D0));
        stream(1 << BAW);
        chk("R6 wrap end", 32'(tx_avail), 32'd0);
        tx_end = 1'b1; step(); tx_end = 1'b0;
        rx_start = 1'b1; step(); rx_start = 1'b0;
        ack_now(0, "R6 ack");

        // R13: link reset mid-packet, then link inactive
        step();
        token(P_IN, DEV, 4'd0);
        step();
        chk("R13 pid before", 32'(tx_pid), 32'(P_D1));
        stream(1);
        link_reset = 1'b1; step(); link_reset = 1'b0;
        chk("R13 reset idle", 32'(tx_avail), 32'd0);
        step();
        chk("R13 reset addr", 32'(buf_addr), 32'd0);
        token(P_IN, DEV, 4'd0);
        step();
        chk("R13 toggle cleared", 32'(tx_pid), 32'(P_D0));
        chk("R13 avail", 32'(tx_avail), 32'd1);
        link_active = 1'b0; step(); link_active = 1'b1;
        chk("R13 inactive idle", 32'(tx_avail), 32'd0);

        step();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule